// File: doc/BRIEF.md
# Logical-to-Physical SIMD Width Sequencer

This block takes one vector instruction at a time and turns it into a series of operations for a four-lane, 32-bit execution pipe. An instruction names a logical width of 1, 2, 4, 8, 16 or 32 lanes, plus a base register for its source operand and a base register for its destination operand. Each register is 32 bytes, which is eight 32-bit elements. An operand wider than eight lanes continues into the next registers in index order.

For each physical pass, the sequencer gives the source and destination register indices. It also says which half of each register the pass covers and which of the four lanes are enabled. It marks the final pass of every instruction. While the final pass is on the outputs, the next instruction can already be accepted, so instructions of mixed widths follow each other with no idle cycle.

An instruction whose operands would run past the top of the register file is refused and produces an error pulse. So is an instruction with an undefined width code. A refused instruction produces no passes.

Top module: `simd_width_seq`

## Requirements
- R1: Width code `in_width` maps 0→1 lane, 1→2, 2→4, 3→8, 4→16, 5→32. The instruction takes 1, 1, 1, 2, 4 and 8 passes respectively.
- R2: `op_lanes` bit i enables lane i. It is 4'b0001 for 1 lane, 4'b0011 for 2 lanes, and 4'b1111 for every wider code.
- R3: On pass k (counted from 0), `op_src` = source base + k/2, `op_dst` = destination base + k/2, and `op_half` = k mod 2.
- R4: `op_last` is high on the final pass of each instruction and on no other cycle.
- R5: An instruction offered while the final pass is showing is accepted on that clock edge. Its first pass follows in the very next cycle, so `op_valid` never drops between the two instructions.
- R6: The register span is 1 register for widths up to 8 lanes, 2 registers for 16 lanes and 4 registers for 32 lanes. If base + span exceeds 128 for either operand, the instruction is refused. `op_err` is high for one cycle, the cycle after acceptance, and `op_valid` stays low.
- R7: Width codes 6 and 7 are refused in the same way as in R6.
- R8: `in_ready` is low while passes remain after the current one. An instruction offered then is not taken and does not disturb the passes in progress.
- R9: After reset `op_valid`, `op_last` and `op_err` are low and `in_ready` is high. Reset in the middle of an instruction abandons it.
- R10: The first pass appears on the outputs in the cycle after the edge that accepts the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_width | input | 3 | Logical width code |
| in_src | input | 7 | Source base register |
| in_dst | input | 7 | Destination base register |
| op_valid | output | 1 | A pass is on the outputs |
| op_src | output | 7 | Source register for this pass |
| op_dst | output | 7 | Destination register for this pass |
| op_half | output | 1 | Which four-lane half of the register |
| op_lanes | output | 4 | Lane enables |
| op_last | output | 1 | Final pass of the instruction |
| op_err | output | 1 | Instruction refused (one-cycle pulse) |

## Verification
The bench targets the register file boundary from both sides: a 32-lane operand at base 124, which fits, and one at base 125, which does not. It does the same with a 16-lane operand at base 127 in the destination field only. An off-by-one in the span check would issue passes past register 127 or would refuse a legal instruction. Instructions are chained with no gap between them, including after refusals. A design that inserts a bubble, or that loses the instruction offered during the final pass, shows up as a missing or late first pass. A request held high through a long instruction checks that the sequencer neither restarts nor corrupts the running passes. A reset in the middle of a pass stream checks that no leftover pass leaks out afterwards.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SW1  = 3'd0,
    SW2  = 3'd1,
    SW4  = 3'd2,
    SW8  = 3'd3,
    SW16 = 3'd4,
    SW32 = 3'd5
  } simd_width_e;
endpackage

// File: rtl/simd_width_decode.sv
module simd_width_decode
  import simd_seq_pkg::*;
#(
  parameter int PHYS_LANES = 4,
  parameter int REG_LANES  = 8,
  parameter int REG_COUNT  = 128,
  parameter int MAX_LANES  = 32,
  localparam int REG_W      = $clog2(REG_COUNT),
  localparam int MAX_PASSES = MAX_LANES / PHYS_LANES,
  localparam int IDX_W      = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1
) (
  input  logic [CODE_W-1:0]     code,
  input  logic [REG_W-1:0]      src_base,
  input  logic [REG_W-1:0]      dst_base,
  output logic [IDX_W-1:0]      last_idx,
  output logic [PHYS_LANES-1:0] lane_mask,
  output logic                  bad
);
  localparam int MAX_CODE = $clog2(MAX_LANES);

  logic        code_ok;
  logic [31:0] lanes;
  logic [31:0] passes;
  logic [31:0] span;
  logic [31:0] src_end;
  logic [31:0] dst_end;

  assign code_ok = (int'(code) <= MAX_CODE);
  assign lanes   = code_ok ? (32'd1 << code) : 32'd1;
  assign passes  = (lanes <= 32'(PHYS_LANES)) ? 32'd1 : lanes / 32'(PHYS_LANES);
  assign span    = (lanes <= 32'(REG_LANES))  ? 32'd1 : lanes / 32'(REG_LANES);
  assign src_end = 32'(src_base) + span;
  assign dst_end = 32'(dst_base) + span;

  assign last_idx = IDX_W'(passes - 32'd1);
  assign bad      = !code_ok || (src_end > 32'(REG_COUNT)) || (dst_end > 32'(REG_COUNT));

  for (genvar i = 0; i < PHYS_LANES; i++) begin : g_mask
    assign lane_mask[i] = (lanes > 32'(i));
  end
endmodule

// File: rtl/simd_pass_gen.sv
module simd_pass_gen #(
  parameter int PHYS_LANES = 4,
  parameter int REG_LANES  = 8,
  parameter int REG_COUNT  = 128,
  parameter int MAX_LANES  = 32,
  localparam int REG_W      = $clog2(REG_COUNT),
  localparam int MAX_PASSES = MAX_LANES / PHYS_LANES,
  localparam int IDX_W      = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1,
  localparam int HALVES     = REG_LANES / PHYS_LANES,
  localparam int HALF_W     = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  reject,
  input  logic [IDX_W-1:0]      last_idx,
  input  logic [PHYS_LANES-1:0] lane_mask,
  input  logic [REG_W-1:0]      src_base,
  input  logic [REG_W-1:0]      dst_base,
  output logic                  op_valid,
  output logic [REG_W-1:0]      op_src,
  output logic [REG_W-1:0]      op_dst,
  output logic [HALF_W-1:0]     op_half,
  output logic [PHYS_LANES-1:0] op_lanes,
  output logic                  op_last,
  output logic                  op_err
);
  localparam int HSHIFT = (HALVES > 1) ? $clog2(HALVES) : 0;

  logic [IDX_W-1:0] pass_idx;
  logic [IDX_W-1:0] last_r;
  logic [REG_W-1:0] src_r;
  logic [REG_W-1:0] dst_r;
  logic [IDX_W-1:0] nxt;
  logic [REG_W-1:0] reg_off;

  assign nxt     = pass_idx + 1'b1;
  assign reg_off = REG_W'(nxt >> HSHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      op_last  <= 1'b0;
      op_err   <= 1'b0;
      op_src   <= '0;
      op_dst   <= '0;
      op_half  <= '0;
      op_lanes <= '0;
      pass_idx <= '0;
      last_r   <= '0;
      src_r    <= '0;
      dst_r    <= '0;
    end else begin
      op_err <= reject;
      if (start) begin
        op_valid <= 1'b1;
        op_src   <= src_base;
        op_dst   <= dst_base;
        op_half  <= '0;
        op_lanes <= lane_mask;
        op_last  <= (last_idx == '0);
        pass_idx <= '0;
        last_r   <= last_idx;
        src_r    <= src_base;
        dst_r    <= dst_base;
      end else if (op_valid && !op_last) begin
        pass_idx <= nxt;
        op_src   <= src_r + reg_off;
        op_dst   <= dst_r + reg_off;
        op_half  <= HALF_W'(nxt) & HALF_W'(HALVES - 1);
        op_last  <= (nxt == last_r);
      end else begin
        op_valid <= 1'b0;
        op_last  <= 1'b0;
      end
    end
  end

  // R4: the final-pass marker only accompanies a live pass
  p_last_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
    op_last |-> op_valid);

  // R6: a refused instruction never produces a pass
  p_err_no_op_r6: assert property (@(posedge clk) disable iff (rst)
    op_err |-> !op_valid);

  // R3: consecutive passes of one instruction alternate register halves
  p_half_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_last) |=> (op_half != $past(op_half)));

  // R3: after the upper half, the register index advances by one
  p_src_step_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_last && op_half == HALF_W'(HALVES - 1))
      |=> (op_src == REG_W'($past(op_src) + 1'b1)));

  // R2: an instruction spanning several passes always uses every lane
  p_full_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_last) |-> (&op_lanes));

  // R10: a pass stream only begins after an accepting edge
  p_start_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(op_valid) |-> $past(start));
endmodule

// File: rtl/simd_width_seq.sv
module simd_width_seq
  import simd_seq_pkg::*;
#(
  parameter int PHYS_LANES = 4,
  parameter int REG_LANES  = 8,
  parameter int REG_COUNT  = 128,
  parameter int MAX_LANES  = 32,
  localparam int REG_W      = $clog2(REG_COUNT),
  localparam int MAX_PASSES = MAX_LANES / PHYS_LANES,
  localparam int IDX_W      = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1,
  localparam int HALVES     = REG_LANES / PHYS_LANES,
  localparam int HALF_W     = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [CODE_W-1:0]     in_width,
  input  logic [REG_W-1:0]      in_src,
  input  logic [REG_W-1:0]      in_dst,
  output logic                  op_valid,
  output logic [REG_W-1:0]      op_src,
  output logic [REG_W-1:0]      op_dst,
  output logic [HALF_W-1:0]     op_half,
  output logic [PHYS_LANES-1:0] op_lanes,
  output logic                  op_last,
  output logic                  op_err
);
  logic [IDX_W-1:0]      dec_last;
  logic [PHYS_LANES-1:0] dec_mask;
  logic                  dec_bad;
  logic                  take;
  logic                  start;
  logic                  reject;

  assign in_ready = !op_valid || op_last;
  assign take     = in_valid && in_ready;
  assign start    = take && !dec_bad;
  assign reject   = take && dec_bad;

  simd_width_decode #(
    .PHYS_LANES(PHYS_LANES), .REG_LANES(REG_LANES),
    .REG_COUNT(REG_COUNT),   .MAX_LANES(MAX_LANES)
  ) u_decode (
    .code      (in_width),
    .src_base  (in_src),
    .dst_base  (in_dst),
    .last_idx  (dec_last),
    .lane_mask (dec_mask),
    .bad       (dec_bad)
  );

  simd_pass_gen #(
    .PHYS_LANES(PHYS_LANES), .REG_LANES(REG_LANES),
    .REG_COUNT(REG_COUNT),   .MAX_LANES(MAX_LANES)
  ) u_passes (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .reject    (reject),
    .last_idx  (dec_last),
    .lane_mask (dec_mask),
    .src_base  (in_src),
    .dst_base  (in_dst),
    .op_valid  (op_valid),
    .op_src    (op_src),
    .op_dst    (op_dst),
    .op_half   (op_half),
    .op_lanes  (op_lanes),
    .op_last   (op_last),
    .op_err    (op_err)
  );

  // R8: while passes remain, nothing new starts
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_last) |=> !$rose(op_err));
endmodule

// File: tb/simd_width_seq_bench.sv
module simd_width_seq_bench;
  import simd_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [2:0] code;
    logic [6:0] src;
    logic [6:0] dst;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 7'd10,  7'd20},
    '{3'd1, 7'd127, 7'd0},
    '{3'd2, 7'd3,   7'd4},
    '{3'd3, 7'd8,   7'd9},
    '{3'd4, 7'd100, 7'd50},
    '{3'd5, 7'd124, 7'd0},
    '{3'd5, 7'd125, 7'd0},
    '{3'd4, 7'd0,   7'd127},
    '{3'd6, 7'd1,   7'd1},
    '{3'd7, 7'd0,   7'd0},
    '{3'd3, 7'd127, 7'd127},
    '{3'd5, 7'd0,   7'd124}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_width = '0;
  logic [6:0] in_src = '0;
  logic [6:0] in_dst = '0;
  logic       op_valid;
  logic [6:0] op_src;
  logic [6:0] op_dst;
  logic [0:0] op_half;
  logic [3:0] op_lanes;
  logic       op_last;
  logic       op_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_width_seq u_simd_width_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_width(in_width), .in_src(in_src), .in_dst(in_dst),
    .op_valid(op_valid), .op_src(op_src), .op_dst(op_dst), .op_half(op_half),
    .op_lanes(op_lanes), .op_last(op_last), .op_err(op_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int n_passes(input int code);
    if (code <= 2) return 1;
    if (code == 3) return 2;
    if (code == 4) return 4;
    return 8;
  endfunction

  function automatic int exp_mask(input int code);
    if (code == 0) return 1;
    if (code == 1) return 3;
    return 15;
  endfunction

  function automatic bit is_bad(input int code, input int s, input int d);
    int span;
    if (code > 5) return 1'b1;
    span = (n_passes(code) + 1) / 2;
    return (s + span > 128) || (d + span > 128);
  endfunction

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input int code, input int s, input int d);
    in_valid = 1'b1;
    in_width = 3'(code);
    in_src   = 7'(s);
    in_dst   = 7'(d);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // checks every pass; returns at the negedge showing the final pass
  task automatic expect_passes(input int code, input int s, input int d);
    int np;
    np = n_passes(code);
    for (int k = 0; k < np; k++) begin
      if (k > 0) @(negedge clk);
      chk(op_valid == 1'b1, (k == 0) ? "R10 R5" : "R10", "op_valid", int'(op_valid), 1);
      chk(op_src == 7'(s + k/2), "R3", "op_src", int'(op_src), s + k/2);
      chk(op_dst == 7'(d + k/2), "R3", "op_dst", int'(op_dst), d + k/2);
      chk(op_half == 1'(k % 2), "R3", "op_half", int'(op_half), k % 2);
      chk(op_lanes == 4'(exp_mask(code)), "R2", "op_lanes", int'(op_lanes), exp_mask(code));
      chk(op_last == (k == np - 1), "R4 R1", "op_last", int'(op_last), int'(k == np - 1));
      chk(op_err == 1'b0, "R6", "op_err", int'(op_err), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(op_valid == 1'b0, "R9", "op_valid after reset", int'(op_valid), 0);
    chk(op_last == 1'b0, "R9", "op_last after reset", int'(op_last), 0);
    chk(op_err == 1'b0, "R9", "op_err after reset", int'(op_err), 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);

    // table walk, back to back; R1 widths, R6/R7 refusals
    for (int i = 0; i < NVEC; i++) begin
      issue(int'(VECS[i].code), int'(VECS[i].src), int'(VECS[i].dst));
      if (is_bad(int'(VECS[i].code), int'(VECS[i].src), int'(VECS[i].dst))) begin
        chk(op_err == 1'b1, "R6 R7", "op_err on refusal", int'(op_err), 1);
        chk(op_valid == 1'b0, "R6 R7", "op_valid on refusal", int'(op_valid), 0);
      end else begin
        expect_passes(int'(VECS[i].code), int'(VECS[i].src), int'(VECS[i].dst));
      end
    end
    @(negedge clk);
    chk(op_valid == 1'b0, "R4", "idle after stream", int'(op_valid), 0);
    chk(op_err == 1'b0, "R6", "error pulse one cycle", int'(op_err), 0);
    chk(in_ready == 1'b1, "R8", "ready when idle", int'(in_ready), 1);

    // R8: request held during a long instruction, then taken at the final pass (R5)
    issue(5, 0, 0);
    in_valid = 1'b1;
    in_width = 3'd0;
    in_src   = 7'd5;
    in_dst   = 7'd6;
    chk(in_ready == 1'b0, "R8", "ready while busy", int'(in_ready), 0);
    expect_passes(5, 0, 0);
    chk(in_ready == 1'b1, "R8", "ready on final pass", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_passes(0, 5, 6);
    @(negedge clk);
    chk(op_valid == 1'b0, "R8", "single instruction taken", int'(op_valid), 0);

    // R9: reset mid-instruction
    issue(4, 1, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(op_valid == 1'b0, "R9", "op_valid after mid reset", int'(op_valid), 0);
    @(negedge clk);
    chk(op_valid == 1'b0, "R9", "no leftover pass", int'(op_valid), 0);
    chk(in_ready == 1'b1, "R9", "ready after mid reset", int'(in_ready), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule